// File: doc/BRIEF.md
# Descriptor Pointer Fetch Queue

This block sits in one channel of a descriptor-driven processing engine. Host software builds a descriptor in memory and hands its location to the channel with a single write of a 64-bit enqueue word. The block keeps up to 24 of these pending pointers in first-in first-out order. Whenever the engine has no descriptor in hand, the block takes the oldest pointer and starts a fetch of that descriptor. The engine is idle either because it has just signalled that the current one is done, or because it has never started.

Only one fetch is outstanding at a time. The current-descriptor-pointer register changes only when that fetch reports completion. It is not updated when the request is raised. The same register supplies the destination address for writing back the modified descriptor header when that notification is switched on.

Addresses are 32 bits wide, or 36 bits when extended addressing is enabled. In extended mode a 4-bit extended pointer carried in the enqueue word is placed on top of the address. The memory transactions and the descriptor processing are outside this block. They appear only as a request/completion handshake and a done pulse.

Top module: `desc_ptr_fetch_queue`

## Requirements
- R1: After reset, count is 0, empty is 1, fetch_req is 0, cur_ptr is all zeros and ovf_err is 0.
- R2: A cycle with enq_valid high and the queue not full stores the pointer held in enq_word[35:0]: bits [35:32] are the extended pointer and bits [31:0] are the address. Bits [63:36] are ignored, and count rises by one.
- R3: The queue holds at most 24 entries. A write that arrives while count is 24 is dropped, and count stays 24. The write then sets ovf_err, which stays high until a cycle with ovf_clear high.
- R4: When no descriptor is fetching or in progress and the queue becomes non-empty, the oldest entry is popped without any done pulse. fetch_req then rises in the cycle after count first shows the entry.
- R5: fetch_req stays high, with fetch_addr unchanged, until a cycle with fetch_ack high. No second fetch is started, and done_pulse has no effect while the fetch is outstanding.
- R6: fetch_addr is {ext, addr} when ext_addr_en is 1, and {4'b0, addr} when it is 0. It is sampled when the entry is popped.
- R7: cur_ptr changes only at the clock edge where fetch_req and fetch_ack are both high. It then takes the popped entry as {28'b0, ext, addr}, and it keeps its old value while the request is pending.
- R8: With a descriptor in progress, a done_pulse pops the next entry and raises fetch_req in the following cycle. If the queue is empty, the block goes idle instead, and fetch_req stays 0.
- R9: Entries leave in the order they were written. An enqueue and a pop in the same cycle leave count unchanged.
- R10: wb_valid equals wb_notify_en. While it is 1, wb_addr is cur_ptr[35:0] formed as in R6 with the present ext_addr_en. While it is 0, wb_addr is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Host write strobe for the enqueue word |
| enq_word | input | 64 | Enqueue word: [35:32] extended pointer, [31:0] address, rest reserved |
| ext_addr_en | input | 1 | Extended-address enable |
| done_pulse | input | 1 | Engine finished the current descriptor |
| fetch_req | output | 1 | Descriptor fetch request |
| fetch_addr | output | 36 | Address of the descriptor to fetch |
| fetch_ack | input | 1 | Fetch completion |
| cur_ptr | output | 64 | Current-descriptor-pointer register |
| wb_notify_en | input | 1 | Header writeback notification enable |
| wb_valid | output | 1 | Writeback address is being driven |
| wb_addr | output | 36 | Header writeback destination |
| ovf_clear | input | 1 | Clears the overflow flag |
| ovf_err | output | 1 | Sticky flag for dropped writes |
| count | output | 5 | Number of queued pointers, 0 to 24 |
| empty | output | 1 | Queue holds no pointers |

## Verification
The first write sets every reserved bit and a nonzero extended pointer. It is read back with extended mode on and then off, which separates correct field slicing and concatenation from passing the raw word through. Writes made while the engine is idle are compared with writes made while a descriptor is busy, to tell the automatic start apart from the done-driven launch. A write is also issued in the same cycle as a done pulse, to confirm that count stays fixed and the order is kept. A fill to 24 followed by one extra write shows that the extra write is dropped and never fetched, and that the error flag is sticky until cleared.

// File: rtl/dpq_pkg.sv
package dpq_pkg;

   typedef enum logic [1:0] {
      FQ_IDLE  = 2'd0,
      FQ_FETCH = 2'd1,
      FQ_BUSY  = 2'd2
   } fq_state_e;

endpackage

// File: rtl/dpq_ptr_fifo.sv
module dpq_ptr_fifo #(
   parameter int DEPTH  = 24,
   parameter int DATA_W = 36,
   localparam int CNT_W = $clog2(DEPTH + 1),
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_req,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_req,
   output logic [DATA_W-1:0] rd_data,
   output logic [CNT_W-1:0]  count,
   output logic              empty,
   output logic              full,
   output logic              wr_drop
);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("dpq_ptr_fifo: DEPTH must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("dpq_ptr_fifo: DATA_W must be positive");
      end
   endgenerate

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CNT_W-1:0]  cnt_q;
   logic              wr_ok, rd_ok;

   assign empty   = (cnt_q == '0);
   assign full    = (cnt_q == CNT_W'(DEPTH));
   assign wr_ok   = wr_req && !full;
   assign rd_ok   = rd_req && !empty;
   assign wr_drop = wr_req && full;
   assign rd_data = mem[rd_ptr];
   assign count   = cnt_q;

   // pointer advance: free wrap for power-of-two depths, compare otherwise
   generate
      if ((1 << PTR_W) == DEPTH) begin : g_pow2
         assign wr_nxt = wr_ptr + PTR_W'(1);
         assign rd_nxt = rd_ptr + PTR_W'(1);
      end else begin : g_wrap
         assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
         assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (wr_ok) mem[wr_ptr] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt_q  <= '0;
      end else begin
         if (wr_ok) wr_ptr <= wr_nxt;
         if (rd_ok) rd_ptr <= rd_nxt;
         case ({wr_ok, rd_ok})
            2'b10:   cnt_q <= cnt_q + CNT_W'(1);
            2'b01:   cnt_q <= cnt_q - CNT_W'(1);
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(DEPTH));

   assert_full_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && full && !rd_req) |=> (cnt_q == CNT_W'(DEPTH)));

   assert_simul_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && !full && rd_req && !empty) |=> $stable(cnt_q));

endmodule

// File: rtl/dpq_addr_fmt.sv
module dpq_addr_fmt #(
   parameter int ADDR_W = 32,
   parameter int EXT_W  = 4,
   localparam int PTR_W = ADDR_W + EXT_W
) (
   input  logic [PTR_W-1:0] raw_ptr,
   input  logic             ext_en,
   output logic [PTR_W-1:0] phys_addr
);

   generate
      if (EXT_W < 1 || ADDR_W < 1) begin : g_bad_fmt
         $error("dpq_addr_fmt: ADDR_W and EXT_W must be positive");
      end
   endgenerate

   logic [EXT_W-1:0] ext_bits;

   assign ext_bits  = ext_en ? raw_ptr[PTR_W-1:ADDR_W] : '0;
   assign phys_addr = {ext_bits, raw_ptr[ADDR_W-1:0]};

endmodule

// File: rtl/dpq_fetch_ctrl.sv
module dpq_fetch_ctrl
   import dpq_pkg::*;
#(
   parameter int PTR_W = 36
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             q_empty,
   input  logic [PTR_W-1:0] head_ptr,
   input  logic [PTR_W-1:0] head_addr,
   input  logic             done_pulse,
   input  logic             fetch_ack,
   output logic             q_pop,
   output logic             fetch_req,
   output logic [PTR_W-1:0] fetch_addr,
   output logic [PTR_W-1:0] cur_raw
);

   fq_state_e        state_q, state_d;
   logic [PTR_W-1:0] pend_q, addr_q, cur_q;
   logic             ack_hit;

   assign ack_hit = (state_q == FQ_FETCH) && fetch_ack;

   always_comb begin
      q_pop   = 1'b0;
      state_d = state_q;
      case (state_q)
         FQ_IDLE: begin
            if (!q_empty) begin
               q_pop   = 1'b1;
               state_d = FQ_FETCH;
            end
         end
         FQ_FETCH: begin
            if (fetch_ack) state_d = FQ_BUSY;
         end
         FQ_BUSY: begin
            if (done_pulse) begin
               q_pop   = !q_empty;
               state_d = q_empty ? FQ_IDLE : FQ_FETCH;
            end
         end
         default: state_d = FQ_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= FQ_IDLE;
         pend_q  <= '0;
         addr_q  <= '0;
         cur_q   <= '0;
      end else begin
         state_q <= state_d;
         if (q_pop) begin
            pend_q <= head_ptr;
            addr_q <= head_addr;
         end
         if (ack_hit) cur_q <= pend_q;
      end
   end

   assign fetch_req  = (state_q == FQ_FETCH);
   assign fetch_addr = addr_q;
   assign cur_raw    = cur_q;

   assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_req && !fetch_ack) |=> (fetch_req && $stable(fetch_addr)));

   assert_cur_on_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(fetch_req && fetch_ack) |=> $stable(cur_raw));

endmodule

// File: rtl/desc_ptr_fetch_queue.sv
module desc_ptr_fetch_queue #(
   parameter int WORD_W = 64,
   parameter int ADDR_W = 32,
   parameter int EXT_W  = 4,
   parameter int DEPTH  = 24,
   localparam int PTR_W = ADDR_W + EXT_W,
   localparam int PAD_W = WORD_W - PTR_W,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enq_valid,
   input  logic [WORD_W-1:0] enq_word,
   input  logic              ext_addr_en,
   input  logic              done_pulse,
   output logic              fetch_req,
   output logic [PTR_W-1:0]  fetch_addr,
   input  logic              fetch_ack,
   output logic [WORD_W-1:0] cur_ptr,
   input  logic              wb_notify_en,
   output logic              wb_valid,
   output logic [PTR_W-1:0]  wb_addr,
   input  logic              ovf_clear,
   output logic              ovf_err,
   output logic [CNT_W-1:0]  count,
   output logic              empty
);

   generate
      if (PAD_W < 1) begin : g_bad_word
         $error("desc_ptr_fetch_queue: WORD_W must exceed ADDR_W + EXT_W");
      end
   endgenerate

   logic [PTR_W-1:0] head_ptr, head_addr, cur_raw, wb_fmt;
   logic             q_pop, q_full, q_empty, wr_drop, ovf_q;
   logic             reserved_unused;

   assign reserved_unused = ^enq_word[WORD_W-1:PTR_W];

   dpq_ptr_fifo #(.DEPTH(DEPTH), .DATA_W(PTR_W)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_req  (enq_valid),
      .wr_data (enq_word[PTR_W-1:0]),
      .rd_req  (q_pop),
      .rd_data (head_ptr),
      .count   (count),
      .empty   (q_empty),
      .full    (q_full),
      .wr_drop (wr_drop)
   );

   dpq_addr_fmt #(.ADDR_W(ADDR_W), .EXT_W(EXT_W)) u_fmt_fetch (
      .raw_ptr   (head_ptr),
      .ext_en    (ext_addr_en),
      .phys_addr (head_addr)
   );

   dpq_fetch_ctrl #(.PTR_W(PTR_W)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .q_empty    (q_empty),
      .head_ptr   (head_ptr),
      .head_addr  (head_addr),
      .done_pulse (done_pulse),
      .fetch_ack  (fetch_ack),
      .q_pop      (q_pop),
      .fetch_req  (fetch_req),
      .fetch_addr (fetch_addr),
      .cur_raw    (cur_raw)
   );

   dpq_addr_fmt #(.ADDR_W(ADDR_W), .EXT_W(EXT_W)) u_fmt_wb (
      .raw_ptr   (cur_raw),
      .ext_en    (ext_addr_en),
      .phys_addr (wb_fmt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)         ovf_q <= 1'b0;
      else if (wr_drop)   ovf_q <= 1'b1;
      else if (ovf_clear) ovf_q <= 1'b0;
   end

   assign ovf_err  = ovf_q;
   assign empty    = q_empty;
   assign cur_ptr  = {{PAD_W{1'b0}}, cur_raw};
   assign wb_valid = wb_notify_en;
   assign wb_addr  = wb_notify_en ? wb_fmt : '0;

   assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_err && !ovf_clear) |=> ovf_err);

   assert_ovf_on_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (enq_valid && count == CNT_W'(DEPTH)) |=> ovf_err);

endmodule

// File: tb/desc_ptr_fetch_queue_test.sv
module desc_ptr_fetch_queue_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enq_valid = 1'b0;
   logic [63:0] enq_word = '0;
   logic        ext_addr_en = 1'b1;
   logic        done_pulse = 1'b0;
   logic        fetch_req;
   logic [35:0] fetch_addr;
   logic        fetch_ack = 1'b0;
   logic [63:0] cur_ptr;
   logic        wb_notify_en = 1'b0;
   logic        wb_valid;
   logic [35:0] wb_addr;
   logic        ovf_clear = 1'b0;
   logic        ovf_err;
   logic [4:0]  count;
   logic        empty;

   int checks = 0;
   int errors = 0;
   logic [35:0] mq[$];

   always #4 clk = ~clk;

   desc_ptr_fetch_queue uut (
      .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_word(enq_word),
      .ext_addr_en(ext_addr_en), .done_pulse(done_pulse), .fetch_req(fetch_req),
      .fetch_addr(fetch_addr), .fetch_ack(fetch_ack), .cur_ptr(cur_ptr),
      .wb_notify_en(wb_notify_en), .wb_valid(wb_valid), .wb_addr(wb_addr),
      .ovf_clear(ovf_clear), .ovf_err(ovf_err), .count(count), .empty(empty)
   );

   function automatic logic [35:0] fmt(input logic [35:0] raw, input logic en);
      return en ? raw : {4'b0, raw[31:0]};
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic enq(input logic [63:0] w, input bit accept);
      @(negedge clk);
      enq_valid = 1'b1;
      enq_word  = w;
      @(negedge clk);
      enq_valid = 1'b0;
      if (accept) mq.push_back(w[35:0]);
   endtask

   task automatic pulse_done();
      @(negedge clk);
      done_pulse = 1'b1;
      @(negedge clk);
      done_pulse = 1'b0;
   endtask

   task automatic expect_fetch(input string tag);
      logic [35:0] raw;
      for (int i = 0; i < 8 && !fetch_req; i++) @(negedge clk);
      chk(fetch_req, {tag, " fetch_req"}, 64'(fetch_req), 64'd1);
      if (mq.size() == 0) begin
         chk(1'b0, {tag, " model empty"}, 64'd0, 64'd1);
         return;
      end
      raw = mq.pop_front();
      chk(fetch_addr == fmt(raw, ext_addr_en), {tag, " fetch_addr"},
          64'(fetch_addr), 64'(fmt(raw, ext_addr_en)));
      fetch_ack = 1'b1;
      @(negedge clk);
      fetch_ack = 1'b0;
      chk(cur_ptr == {28'b0, raw}, {tag, " R7 cur_ptr"}, cur_ptr, {28'b0, raw});
      chk(!fetch_req, {tag, " R5 req drops"}, 64'(fetch_req), 64'd0);
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(count == 0, "R1 count", 64'(count), 64'd0);
      chk(empty, "R1 empty", 64'(empty), 64'd1);
      chk(!fetch_req, "R1 fetch_req", 64'(fetch_req), 64'd0);
      chk(cur_ptr == 0, "R1 cur_ptr", cur_ptr, 64'd0);
      chk(!ovf_err, "R1 ovf_err", 64'(ovf_err), 64'd0);
   endtask

   task automatic t_single();
      logic [35:0] a;
      ext_addr_en  = 1'b1;
      wb_notify_en = 1'b1;
      enq(64'hFFFF_FFF5_1234_5670, 1'b1);
      chk(count == 1, "R2 count after write", 64'(count), 64'd1);
      chk(!fetch_req, "R4 no req yet", 64'(fetch_req), 64'd0);
      @(negedge clk);
      chk(fetch_req, "R4 auto start", 64'(fetch_req), 64'd1);
      chk(fetch_addr == 36'h5_1234_5670, "R6 ext addr", 64'(fetch_addr), 64'h5_1234_5670);
      chk(empty && count == 0, "R4 popped", 64'(count), 64'd0);
      chk(cur_ptr == 0, "R7 unchanged at request", cur_ptr, 64'd0);
      a = fetch_addr;
      done_pulse = 1'b1;
      repeat (3) @(negedge clk);
      done_pulse = 1'b0;
      chk(fetch_req && fetch_addr == a, "R5 held", 64'(fetch_addr), 64'(a));
      chk(cur_ptr == 0, "R7 still zero while pending", cur_ptr, 64'd0);
      expect_fetch("R2 single");
      chk(wb_valid && wb_addr == 36'h5_1234_5670, "R10 wb ext", 64'(wb_addr), 64'h5_1234_5670);
      ext_addr_en = 1'b0;
      #1;
      chk(wb_addr == 36'h0_1234_5670, "R10 wb no ext", 64'(wb_addr), 64'h0_1234_5670);
      wb_notify_en = 1'b0;
      #1;
      chk(!wb_valid && wb_addr == 0, "R10 wb off", 64'(wb_addr), 64'd0);
   endtask

   task automatic t_order();
      ext_addr_en = 1'b0;
      enq(64'h0000_000A_0000_1000, 1'b1);
      enq(64'h0000_000B_0000_2000, 1'b1);
      enq(64'h0000_000C_0000_3000, 1'b1);
      @(negedge clk);
      chk(!fetch_req && count == 3, "R8 busy waits for done", 64'(count), 64'd3);
      enq_valid  = 1'b1;
      enq_word   = 64'h0000_000D_0000_4000;
      done_pulse = 1'b1;
      @(negedge clk);
      enq_valid  = 1'b0;
      done_pulse = 1'b0;
      mq.push_back(36'hD_0000_4000);
      chk(count == 3, "R9 simultaneous count", 64'(count), 64'd3);
      chk(fetch_req, "R8 done launches", 64'(fetch_req), 64'd1);
      expect_fetch("R9 first");
      for (int i = 0; i < 3; i++) begin
         pulse_done();
         expect_fetch("R9 order");
      end
      pulse_done();
      @(negedge clk);
      chk(!fetch_req && empty, "R8 idle when empty", 64'(fetch_req), 64'd0);
      ext_addr_en = 1'b1;
      enq(64'h0000_0003_0000_5000, 1'b1);
      expect_fetch("R4 restart");
   endtask

   task automatic t_full();
      for (int i = 0; i < 24; i++)
         enq(64'(36'h7_0000_0000 + 36'(i * 16)), 1'b1);
      chk(count == 24, "R3 full count", 64'(count), 64'd24);
      chk(!ovf_err, "R3 no ovf yet", 64'(ovf_err), 64'd0);
      enq(64'h0000_0009_DEAD_0000, 1'b0);
      chk(count == 24, "R3 dropped", 64'(count), 64'd24);
      chk(ovf_err, "R3 ovf set", 64'(ovf_err), 64'd1);
      repeat (3) @(negedge clk);
      chk(ovf_err, "R3 ovf sticky", 64'(ovf_err), 64'd1);
      ovf_clear = 1'b1;
      @(negedge clk);
      ovf_clear = 1'b0;
      chk(!ovf_err, "R3 ovf cleared", 64'(ovf_err), 64'd0);
      for (int i = 0; i < 24; i++) begin
         pulse_done();
         expect_fetch("R3 R9 drain");
      end
      pulse_done();
      repeat (2) @(negedge clk);
      chk(!fetch_req && empty, "R3 extra never fetched", 64'(fetch_req), 64'd0);
   endtask

   initial begin
      t_reset();
      t_single();
      t_order();
      t_full();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule